// File: doc/BRIEF.md
# Two-Wire Configuration Receiver

This block listens on a two-wire serial bus as a write-only target. It fills a bank of eight 8-bit configuration registers that the rest of the chip reads directly. Every write is a fixed frame of eleven bytes in this order: a target address, two header bytes (a command code and a byte count), and eight payload bytes. The receiver checks the address and ignores what the two header bytes hold. It still counts both header bytes, so each payload byte reaches its own register.

The bus lines are sampled by the system clock through a synchronizer. The receiver detects START and STOP, gathers bits MSB first on each rising clock-line edge, and pulls the data line low to acknowledge each byte of a frame addressed to it. Reset loads a fixed default value into every register, so the chip runs correctly even if no frame is ever sent. Reserved register bits always read as zero.

Top module: `twcfg_rx`

## Requirements
- R1: After reset every register holds its default value (register i on `cfg_bank[8i+7:8i]`; defaults 8'h3C for register 0, 8'hF0 for register 7, 8'hFF for the rest).
- R2: When the first byte after START equals `DEV_ADDR` (default 8'hD2), the receiver drives `sda_drive_low` during the ninth clock of that byte and of every later byte in the frame. It changes the drive only while the clock line is low.
- R3: When the first byte differs from `DEV_ADDR`, the receiver sends no acknowledge and changes no register until the next START.
- R4: The second and third bytes have no effect on any register. Payload bytes 0 to 7 (frame bytes 4 to 11) go to registers 0 to 7 in that order.
- R5: A payload byte is committed only after the falling clock-line edge that ends its ninth clock. Until that edge the register keeps its old value.
- R6: Reserved bits always read 0, whatever value was written. The reserved bits are bit 7 of register 0 and bits 3:0 of register 7.
- R7: Bytes after the eighth payload byte are acknowledged but change no register.
- R8: A STOP or a repeated START inside a frame resets the byte position to the address byte. Registers committed before it keep their new values.
- R9: START is the data line falling while the clock line is high. STOP is the data line rising while the clock line is high. Bits are sampled on the clock line's rising edge, MSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired-AND with the receiver's pull-down) |
| sda_drive_low | output | 1 | High when the receiver pulls the data line low to acknowledge |
| cfg_bank | output | 64 | Register bank; register i on bits 8i+7:8i |

## Verification
The bench goes after the address byte first. If the comparison is off by one bit, a frame meant for another target would load the bank, or a valid frame would get no acknowledge. It varies the two header bytes to show that they are skipped but still counted; a counter that forgot them would shift the whole payload by two registers. It sends a frame with a twelfth byte, and frames cut short by a STOP or by a repeated START. A design that saturated its position badly, or failed to restart it, would write the extra byte into a register or land the restarted payload in the wrong slots. It also reads the bank during the ninth clock, which catches a design that commits on the rising edge instead of the falling one.

// File: rtl/twcfg_pkg.sv
package twcfg_pkg;

    localparam int REG_W     = 8;
    localparam int NREG      = 8;
    localparam int BANK_W    = REG_W * NREG;
    localparam int REG_IDX_W = $clog2(NREG);
    localparam int HDR_BYTES = 3;
    localparam int IDX_W     = $clog2(HDR_BYTES + NREG + 1);
    localparam int BIT_CNT_W = $clog2(REG_W);

    localparam logic [IDX_W-1:0]     FIRST_DATA_SLOT = IDX_W'(HDR_BYTES);
    localparam logic [IDX_W-1:0]     OVERFLOW_SLOT   = IDX_W'(HDR_BYTES + NREG);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT        = BIT_CNT_W'(REG_W - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BITS,
        ST_ACK_WAIT,
        ST_ACK,
        ST_IGNORE
    } rx_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic                 valid;
        logic [REG_IDX_W-1:0] idx;
        logic [REG_W-1:0]     data;
    } reg_wr_t;

    function automatic logic is_data_slot(input logic [IDX_W-1:0] slot);
        return (slot >= FIRST_DATA_SLOT) && (slot < OVERFLOW_SLOT);
    endfunction

    function automatic logic [REG_IDX_W-1:0] slot_to_reg(input logic [IDX_W-1:0] slot);
        return REG_IDX_W'(slot - FIRST_DATA_SLOT);
    endfunction

    function automatic logic [REG_W-1:0] clear_reserved(input logic [REG_W-1:0] value,
                                                        input logic [REG_W-1:0] mask);
        return value & ~mask;
    endfunction

endpackage

// File: rtl/twcfg_line_sync.sv
module twcfg_line_sync
    import twcfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_now;
    logic              sda_now;

    // Idle bus is high on both lines, so reset to ones.
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_now;
            sda_q    <= sda_now;
        end
    end

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_comb begin
        evt.rise  = scl_now & ~scl_q;
        evt.fall  = ~scl_now & scl_q;
        evt.start = scl_now & scl_q & sda_q & ~sda_now;
        evt.stop  = scl_now & scl_q & ~sda_q & sda_now;
        evt.sda   = sda_now;
    end

endmodule

// File: rtl/twcfg_frame_seq.sv
module twcfg_frame_seq
    import twcfg_pkg::*;
#(
    parameter logic [REG_W-1:0] DEV_ADDR = 8'hD2
) (
    input  logic      clk,
    input  logic      rst,
    input  bus_evt_t  evt,
    output reg_wr_t   wr,
    output logic      drive_low,
    output rx_state_e state
);

    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [REG_W-1:0]     shreg;
    logic [IDX_W-1:0]     slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            slot      <= '0;
            drive_low <= 1'b0;
            wr        <= '0;
        end else begin
            wr.valid <= 1'b0;
            if (evt.start) begin
                // START or repeated START: frame restarts at the address byte
                state     <= ST_BITS;
                bit_cnt   <= '0;
                slot      <= '0;
                drive_low <= 1'b0;
            end else if (evt.stop) begin
                state     <= ST_IDLE;
                bit_cnt   <= '0;
                slot      <= '0;
                drive_low <= 1'b0;
            end else begin
                case (state)
                    ST_BITS: begin
                        if (evt.rise) begin
                            shreg <= {shreg[REG_W-2:0], evt.sda};
                            if (bit_cnt == LAST_BIT) begin
                                bit_cnt <= '0;
                                state   <= ST_ACK_WAIT;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_ACK_WAIT: begin
                        if (evt.fall) begin
                            if ((slot == '0) && (shreg != DEV_ADDR)) begin
                                state <= ST_IGNORE;
                            end else begin
                                drive_low <= 1'b1;
                                state     <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.fall) begin
                            drive_low <= 1'b0;
                            if (is_data_slot(slot)) begin
                                wr.valid <= 1'b1;
                                wr.idx   <= slot_to_reg(slot);
                                wr.data  <= shreg;
                            end
                            if (slot != OVERFLOW_SLOT) begin
                                slot <= slot + 1'b1;
                            end
                            state <= ST_BITS;
                        end
                    end
                    default: begin
                        // ST_IDLE and ST_IGNORE wait for the next START
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/twcfg_reg_bank.sv
module twcfg_reg_bank
    import twcfg_pkg::*;
#(
    parameter logic [BANK_W-1:0] DEFAULTS  = '0,
    parameter logic [BANK_W-1:0] RSVD_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr,
    output logic [BANK_W-1:0] bank
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [REG_W-1:0] value;

        always_ff @(posedge clk) begin
            if (rst) begin
                value <= DEFAULTS[i*REG_W +: REG_W];
            end else if (wr.valid && (wr.idx == REG_IDX_W'(i))) begin
                value <= clear_reserved(wr.data, RSVD_MASK[i*REG_W +: REG_W]);
            end
        end

        assign bank[i*REG_W +: REG_W] = value;
    end

endmodule

// File: rtl/twcfg_rx.sv
module twcfg_rx
    import twcfg_pkg::*;
#(
    parameter logic [REG_W-1:0]  DEV_ADDR    = 8'hD2,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BANK_W-1:0] DEFAULTS    = 64'hF0FF_FFFF_FFFF_FF3C,
    parameter logic [BANK_W-1:0] RSVD_MASK   = 64'h0F00_0000_0000_0080
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low,
    output logic [BANK_W-1:0] cfg_bank
);

    bus_evt_t  evt;
    reg_wr_t   wr;
    rx_state_e fsm_state;

    twcfg_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    twcfg_frame_seq #(
        .DEV_ADDR (DEV_ADDR)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .wr        (wr),
        .drive_low (sda_drive_low),
        .state     (fsm_state)
    );

    twcfg_reg_bank #(
        .DEFAULTS  (DEFAULTS),
        .RSVD_MASK (RSVD_MASK)
    ) u_bank (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .bank (cfg_bank)
    );

endmodule

// File: rtl/twcfg_rx_chk.sv
module twcfg_rx_chk
    import twcfg_pkg::*;
#(
    parameter logic [BANK_W-1:0] DEFAULTS  = '0,
    parameter logic [BANK_W-1:0] RSVD_MASK = '0
) (
    input logic              clk,
    input logic              rst,
    input logic [BANK_W-1:0] cfg_bank,
    input logic              sda_drive_low,
    input logic              bus_fall,
    input rx_state_e         state
);

    // R1
    reset_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_bank == DEFAULTS);

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_bank & RSVD_MASK) == '0);

    // R5
    commit_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(cfg_bank)) |-> $past(bus_fall, 2));

    // R2
    ack_only_in_ack_chk: assert property (@(posedge clk) disable iff (rst)
        sda_drive_low |-> state == ST_ACK);

    // R2
    ack_starts_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(sda_drive_low)) |-> $past(bus_fall));

    // R3
    ignore_silent_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_IGNORE |-> !sda_drive_low);

    // R3
    ignore_holds_bank_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_IGNORE |=> $stable(cfg_bank));

endmodule

bind twcfg_rx twcfg_rx_chk #(
    .DEFAULTS  (DEFAULTS),
    .RSVD_MASK (RSVD_MASK)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_bank      (cfg_bank),
    .sda_drive_low (sda_drive_low),
    .bus_fall      (evt.fall),
    .state         (fsm_state)
);

// File: tb/twcfg_rx_tb.sv
module twcfg_rx_tb;

    localparam logic [63:0] DEF_BANK = 64'hF0FF_FFFF_FFFF_FF3C;
    localparam logic [63:0] RSVD     = 64'h0F00_0000_0000_0080;
    localparam int          H        = 8;

    // {match, address, command, count, payload (byte k at bits 8k+7:8k)}
    localparam logic [88:0] VEC [4] = '{
        {1'b1, 8'hD2, 8'h00, 8'h08, 64'h7F67_5645_3423_1281},
        {1'b0, 8'hD3, 8'h00, 8'h08, 64'hAAAA_AAAA_AAAA_AAAA},
        {1'b0, 8'h52, 8'h11, 8'h08, 64'h5555_5555_5555_5555},
        {1'b1, 8'hD2, 8'hFF, 8'h00, 64'hFFF0_0FFF_00A5_5AC3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_drive_low;
    logic [63:0] cfg_bank;
    logic        sda_line;
    logic [63:0] exp_bank;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = m_sda & ~sda_drive_low;

    twcfg_rx u_dut (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (m_scl),
        .sda_i         (sda_line),
        .sda_drive_low (sda_drive_low),
        .cfg_bank      (cfg_bank)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        m_scl = 1'b1;
        wait_clks(H);
        m_sda = 1'b0;
        wait_clks(H);
        m_scl = 1'b0;
    endtask

    task automatic bus_rstart();
        wait_clks(2);
        m_sda = 1'b1;
        wait_clks(H);
        m_scl = 1'b1;
        wait_clks(H);
        m_sda = 1'b0;
        wait_clks(H);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clks(2);
        m_sda = 1'b0;
        wait_clks(H);
        m_scl = 1'b1;
        wait_clks(H);
        m_sda = 1'b1;
        wait_clks(H);
    endtask

    task automatic send_bits(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wait_clks(2);
            m_sda = b[i];
            wait_clks(H);
            m_scl = 1'b1;
            wait_clks(H);
            m_scl = 1'b0;
        end
    endtask

    // Ninth clock up to its high phase; leaves clock high.
    task automatic ack_rise(output logic ack);
        wait_clks(2);
        m_sda = 1'b1;
        wait_clks(H);
        m_scl = 1'b1;
        wait_clks(H / 2);
        ack = ~sda_line;
        wait_clks(H / 2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b);
        ack_rise(ack);
        m_scl = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [7:0] c, input logic [7:0] n,
                              input logic [63:0] d, output logic [10:0] acks);
        logic ak;
        bus_start();
        send_byte(a, ak); acks[0] = ak;
        send_byte(c, ak); acks[1] = ak;
        send_byte(n, ak); acks[2] = ak;
        for (int k = 0; k < 8; k++) begin
            send_byte(d[8*k +: 8], ak);
            acks[3+k] = ak;
        end
    endtask

    initial begin
        logic [10:0] acks;
        logic        ak;
        logic [88:0] v;

        wait_clks(5);
        rst = 1'b0;
        wait_clks(5);
        // R1: defaults after reset
        chk("R1 reset defaults", cfg_bank, DEF_BANK);
        exp_bank = DEF_BANK;

        // R2 R3 R4 R6 R9: table of whole frames
        for (int i = 0; i < 4; i++) begin
            v = VEC[i];
            send_frame(v[87:80], v[79:72], v[71:64], v[63:0], acks);
            bus_stop();
            if (v[88]) exp_bank = v[63:0] & ~RSVD;
            chk(v[88] ? "R2 ack on match" : "R3 silent on mismatch",
                64'(acks), v[88] ? 64'h7FF : 64'h0);
            chk("R4 R6 bank after frame", cfg_bank, exp_bank);
        end

        // R5: bank unchanged during ninth clock, updated after its fall
        bus_start();
        send_byte(8'hD2, ak);
        send_byte(8'h00, ak);
        send_byte(8'h08, ak);
        send_bits(8'h3C);
        ack_rise(ak);
        chk("R5 no commit before ninth fall", cfg_bank, exp_bank);
        m_scl = 1'b0;
        wait_clks(6);
        exp_bank[7:0] = 8'h3C;
        chk("R5 commit after ninth fall", cfg_bank, exp_bank);
        bus_stop();

        // R7: twelfth byte acknowledged, discarded
        send_frame(8'hD2, 8'h01, 8'h02, 64'h1020_3040_5060_7001, acks);
        send_byte(8'hEE, ak);
        bus_stop();
        exp_bank = 64'h1020_3040_5060_7001 & ~RSVD;
        chk("R7 extra byte acknowledged", 64'(ak), 64'h1);
        chk("R7 extra byte discarded", cfg_bank, exp_bank);

        // R8: STOP after two payload bytes keeps them, rest untouched
        bus_start();
        send_byte(8'hD2, ak);
        send_byte(8'h00, ak);
        send_byte(8'h08, ak);
        send_byte(8'h11, ak);
        send_byte(8'h22, ak);
        bus_stop();
        exp_bank[15:0] = 16'h2211;
        chk("R8 partial frame after STOP", cfg_bank, exp_bank);

        // R8: repeated START mid-frame restarts at the address byte
        bus_start();
        send_byte(8'hD2, ak);
        send_byte(8'h00, ak);
        send_byte(8'h08, ak);
        send_byte(8'h99, ak);
        exp_bank[7:0] = 8'h19;
        bus_rstart();
        send_byte(8'hD2, ak); acks[0] = ak;
        send_byte(8'h05, ak); acks[1] = ak;
        send_byte(8'h06, ak); acks[2] = ak;
        for (int k = 0; k < 8; k++) begin
            send_byte(8'(8'h41 + k), ak);
            acks[3+k] = ak;
        end
        bus_stop();
        exp_bank = 64'h4847_4645_4443_4241 & ~RSVD;
        chk("R8 frame after repeated START", cfg_bank, exp_bank);
        chk("R8 acks after repeated START", 64'(acks), 64'h7FF);

        // R3: mismatched address followed by payload leaves bank
        send_frame(8'hD0, 8'h00, 8'h08, 64'h0, acks);
        bus_stop();
        chk("R3 mismatch keeps bank", cfg_bank, exp_bank);

        // R1: reset while running restores defaults
        rst = 1'b1;
        wait_clks(2);
        rst = 1'b0;
        wait_clks(2);
        chk("R1 defaults after second reset", cfg_bank, DEF_BANK);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule